// File: doc/BRIEF.md
# Step sequencer with timer and counter

This block is the decision core of a trigger unit. An external condition evaluator presents one hit flag per condition for the step the sequencer is currently in. On each clock the sequencer picks an action word and applies it. The word comes from the lowest-numbered condition that is true. When no condition is true, it comes from the step's default word. An action can move to another step, pulse the trigger outputs, drive a free-running timer and an up/down counter, and latch a sticky done flag.

Each step holds its own timer compare value. The sequencer reports whether the timer has reached that value, and the evaluator can use this as a condition input. Configuration is loaded through a plain write port. A reset command disables the unit and wipes all configuration. An enable command starts the sequence at step 0. All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `step_seq`

## Requirements
- R1: After `rst_n` low, or one cycle after `cmd_reset`, the sequencer is stopped: `running_o`=0, step 0, timer 0, count 0, `done_o`=0 and all triggers 0. `cmd_reset` also zeroes every stored action word, default word and compare value, and it wins over `cmd_enable` and over writes.
- R2: One cycle after `cmd_enable` (without `cmd_reset`), `running_o`=1, the step is 0, and timer, counter and timer-run state are cleared. No action is applied in that cycle.
- R3: When several condition flags are true in a cycle, only the action word of the lowest-numbered true condition is applied.
- R4: When no condition flag is true, the current step's default word is applied. Its next-step field is ignored and the step is held.
- R5: A condition action loads the step register from action bits [18:17], visible one cycle later.
- R6: Action bit 13 produces a one-cycle high on `trig_irq_o`, `trig_cti_o` and `trig_xunit_o`, in the cycle after each cycle in which it is applied.
- R7: Timer: bit 3 starts it, bit 2 stops it (stop beats start), and bit 1 zeroes it. Zeroing beats counting in that cycle. While started, the timer adds one per clock and saturates at its maximum. Counting begins the cycle after the start action.
- R8: `timer_ge_o` is 1 exactly when the timer is greater than or equal to the compare value of the current step.
- R9: Counter: bit 9 adds one, bit 8 subtracts one, and both together leave it unchanged. Bit 7 zeroes it and beats both. The counter saturates at its maximum and at zero.
- R10: Action bit 0 sets `done_o`, which then stays 1 through later actions and re-enables until `cmd_reset` or `rst_n`.
- R11: While stopped, condition flags have no effect: step, timer, counter, done and triggers keep their values.
- R12: With step 0 conditions 0 and 1 set to 0x20008, step 1 condition 0 set to 0x6 and fed by `timer_ge_o`, step 1 default set to 0x2000 and step 1 compare set to 3, a pattern hit gives exactly three trigger pulses and then a return to step 0 with the timer zeroed and stopped.
- R13: A write with `cfg_we`=1 stores `cfg_data` according to `cfg_kind`: 0 stores the action of condition `cfg_cond` of step `cfg_step`, 1 stores that step's default word, and 2 stores the low timer-width bits as that step's compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | Stop and wipe configuration |
| cmd_enable | input | 1 | Start the sequence at step 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 condition action, 1 default, 2 compare |
| cfg_step | input | SW | Step addressed by the write |
| cfg_cond | input | CIW | Condition addressed by the write |
| cfg_data | input | 32 | Write data |
| cond_hit | input | NCOND | Condition flags for the current step |
| step_o | output | SW | Current step |
| running_o | output | 1 | Sequencer started |
| timer_o | output | TW | Timer value |
| timer_ge_o | output | 1 | Timer reached current step's compare value |
| count_o | output | CW | Counter value |
| done_o | output | 1 | Sticky done flag |
| trig_irq_o | output | 1 | Trigger toward processor interrupt |
| trig_cti_o | output | 1 | Trigger toward cross-trigger interface |
| trig_xunit_o | output | 1 | Trigger toward other trigger units |

## Verification
A wrong priority choice or a wrong decode of the next-step field shows on `step_o` one clock after the offending cycle. A timer or counter that counts one cycle too early, or misses its saturation, diverges from a running arithmetic model on `timer_o`/`count_o` within the same clock. It also moves `timer_ge_o` at the wrong cycle. A lost or stuck run state therefore shows up as a trigger count other than three in the timer-driven scenario. Leftover configuration after a reset command shows as a step change or a trigger on the first hit after the next enable.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int ACT_W    = 32;
  localparam int B_NXT_LO = 17;
  localparam int B_NXT_HI = 18;
  localparam int B_TRIG   = 13;
  localparam int B_CINC   = 9;
  localparam int B_CDEC   = 8;
  localparam int B_CCLR   = 7;
  localparam int B_TSTART = 3;
  localparam int B_TSTOP  = 2;
  localparam int B_TZERO  = 1;
  localparam int B_DONE   = 0;

  typedef enum logic [1:0] {
    KIND_COND = 2'd0,
    KIND_DFLT = 2'd1,
    KIND_CMP  = 2'd2
  } cfg_kind_e;

  typedef struct packed {
    logic [1:0] nxt;
    logic       trig;
    logic       cinc;
    logic       cdec;
    logic       cclr;
    logic       tstart;
    logic       tstop;
    logic       tzero;
    logic       done;
  } act_t;

  function automatic act_t decode_act(input logic [ACT_W-1:0] w);
    act_t a;
    a.nxt    = w[B_NXT_HI:B_NXT_LO];
    a.trig   = w[B_TRIG];
    a.cinc   = w[B_CINC];
    a.cdec   = w[B_CDEC];
    a.cclr   = w[B_CCLR];
    a.tstart = w[B_TSTART];
    a.tstop  = w[B_TSTOP];
    a.tzero  = w[B_TZERO];
    a.done   = w[B_DONE];
    return a;
  endfunction
endpackage

// File: rtl/seq_cfg_store.sv
module seq_cfg_store
  import step_seq_pkg::*;
#(
  parameter int NSTEP = 4,
  parameter int NCOND = 4,
  parameter int TW    = 16,
  localparam int SW   = $clog2(NSTEP),
  localparam int CIW  = $clog2(NCOND)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wipe,
  input  logic                        we,
  input  logic [1:0]                  kind,
  input  logic [SW-1:0]               wr_step,
  input  logic [CIW-1:0]              wr_cond,
  input  logic [ACT_W-1:0]            wr_data,
  input  logic [SW-1:0]               rd_step,
  output logic [NCOND-1:0][ACT_W-1:0] rd_acts,
  output logic [ACT_W-1:0]            rd_dflt,
  output logic [TW-1:0]               rd_cmp
);
  logic [NSTEP-1:0][NCOND-1:0][ACT_W-1:0] act_q;
  logic [NSTEP-1:0][ACT_W-1:0]            dflt_q;
  logic [NSTEP-1:0][TW-1:0]               cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      dflt_q <= '0;
      cmp_q  <= '0;
    end else if (wipe) begin
      act_q  <= '0;
      dflt_q <= '0;
      cmp_q  <= '0;
    end else if (we) begin
      case (kind)
        KIND_COND: act_q[wr_step][wr_cond] <= wr_data;
        KIND_DFLT: dflt_q[wr_step]         <= wr_data;
        KIND_CMP:  cmp_q[wr_step]          <= wr_data[TW-1:0];
        default: ;
      endcase
    end
  end

  assign rd_acts = act_q[rd_step];
  assign rd_dflt = dflt_q[rd_step];
  assign rd_cmp  = cmp_q[rd_step];
endmodule

// File: rtl/seq_cond_pick.sv
module seq_cond_pick
  import step_seq_pkg::*;
#(
  parameter int NCOND = 4
) (
  input  logic [NCOND-1:0]            hit,
  input  logic [NCOND-1:0][ACT_W-1:0] acts,
  input  logic [ACT_W-1:0]            dflt,
  output logic [ACT_W-1:0]            chosen,
  output logic                        any_hit
);
  always_comb begin
    chosen = dflt;
    for (int i = NCOND - 1; i >= 0; i--) begin
      if (hit[i]) chosen = acts[i];
    end
  end
  assign any_hit = |hit;
endmodule

// File: rtl/seq_timer_ctr.sv
module seq_timer_ctr
  import step_seq_pkg::*;
#(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe,
  input  logic          apply,
  input  act_t          act,
  input  logic [TW-1:0] cmp,
  output logic [TW-1:0] timer,
  output logic [CW-1:0] count,
  output logic          ge
);
  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [CW-1:0] CMAX = '1;

  logic run_q;
  logic tzero, tstop, tstart, cclr, cinc, cdec;

  assign tzero  = apply & act.tzero;
  assign tstop  = apply & act.tstop;
  assign tstart = apply & act.tstart;
  assign cclr   = apply & act.cclr;
  assign cinc   = apply & act.cinc & ~act.cdec;
  assign cdec   = apply & act.cdec & ~act.cinc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      timer <= '0;
    end else if (wipe) begin
      run_q <= 1'b0;
      timer <= '0;
    end else begin
      if (tstop)       run_q <= 1'b0;
      else if (tstart) run_q <= 1'b1;
      if (tzero)                                 timer <= '0;
      else if (apply && run_q && timer != TMAX)  timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (wipe || cclr)               count <= '0;
    else if (cinc && count != CMAX)      count <= count + 1'b1;
    else if (cdec && count != '0)        count <= count - 1'b1;
  end

  assign ge = (timer >= cmp);
endmodule

// File: rtl/step_seq.sv
module step_seq
  import step_seq_pkg::*;
#(
  parameter int NSTEP = 4,
  parameter int NCOND = 4,
  parameter int TW    = 16,
  parameter int CW    = 8,
  localparam int SW   = $clog2(NSTEP),
  localparam int CIW  = $clog2(NCOND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_reset,
  input  logic             cmd_enable,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [SW-1:0]    cfg_step,
  input  logic [CIW-1:0]   cfg_cond,
  input  logic [31:0]      cfg_data,
  input  logic [NCOND-1:0] cond_hit,
  output logic [SW-1:0]    step_o,
  output logic             running_o,
  output logic [TW-1:0]    timer_o,
  output logic             timer_ge_o,
  output logic [CW-1:0]    count_o,
  output logic             done_o,
  output logic             trig_irq_o,
  output logic             trig_cti_o,
  output logic             trig_xunit_o
);
  logic [NCOND-1:0][ACT_W-1:0] acts;
  logic [ACT_W-1:0]            dflt, chosen;
  logic [TW-1:0]               cmp;
  logic                        any_hit, apply, trig_q;
  act_t                        act;

  assign apply = running_o & ~cmd_reset & ~cmd_enable;
  assign act   = decode_act(chosen);

  seq_cfg_store #(.NSTEP(NSTEP), .NCOND(NCOND), .TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .wipe(cmd_reset), .we(cfg_we), .kind(cfg_kind),
    .wr_step(cfg_step), .wr_cond(cfg_cond), .wr_data(cfg_data),
    .rd_step(step_o), .rd_acts(acts), .rd_dflt(dflt), .rd_cmp(cmp)
  );

  seq_cond_pick #(.NCOND(NCOND)) u_pick (
    .hit(cond_hit), .acts(acts), .dflt(dflt), .chosen(chosen), .any_hit(any_hit)
  );

  seq_timer_ctr #(.TW(TW), .CW(CW)) u_tc (
    .clk(clk), .rst_n(rst_n), .wipe(cmd_reset | cmd_enable), .apply(apply),
    .act(act), .cmp(cmp), .timer(timer_o), .count(count_o), .ge(timer_ge_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_o <= 1'b0;
      step_o    <= '0;
      done_o    <= 1'b0;
      trig_q    <= 1'b0;
    end else if (cmd_reset) begin
      running_o <= 1'b0;
      step_o    <= '0;
      done_o    <= 1'b0;
      trig_q    <= 1'b0;
    end else if (cmd_enable) begin
      running_o <= 1'b1;
      step_o    <= '0;
      trig_q    <= 1'b0;
    end else begin
      trig_q <= apply & act.trig;
      if (apply && any_hit) step_o <= SW'(act.nxt);
      if (apply && act.done) done_o <= 1'b1;
    end
  end

  assign trig_irq_o   = trig_q;
  assign trig_cti_o   = trig_q;
  assign trig_xunit_o = trig_q;
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
  parameter int SW = 2,
  parameter int TW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_reset,
  input logic          cmd_enable,
  input logic          running_o,
  input logic [SW-1:0] step_o,
  input logic [TW-1:0] timer_o,
  input logic [CW-1:0] count_o,
  input logic          done_o,
  input logic          trig_irq_o
);
  AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!running_o && !done_o && step_o == '0 && timer_o == '0)); // R1
  AST_ENABLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_enable && !cmd_reset) |=> (running_o && step_o == '0 && timer_o == '0 && count_o == '0)); // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cmd_reset) |=> done_o); // R10
  AST_IDLE_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> !trig_irq_o); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !cmd_enable && !cmd_reset) |=> ($stable(step_o) && $stable(timer_o) && $stable(count_o))); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !cmd_enable && !cmd_reset) |=> (count_o == $past(count_o) || count_o == $past(count_o) + CW'(1)
      || count_o == $past(count_o) - CW'(1) || count_o == '0)); // R9
  AST_TIMER_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !cmd_enable && !cmd_reset) |=> (timer_o == '0 || timer_o == $past(timer_o)
      || timer_o == $past(timer_o) + TW'(1))); // R7
endmodule

bind step_seq step_seq_chk #(.SW(SW), .TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_enable(cmd_enable),
  .running_o(running_o), .step_o(step_o), .timer_o(timer_o), .count_o(count_o),
  .done_o(done_o), .trig_irq_o(trig_irq_o)
);

// File: tb/step_seq_bench.sv
`timescale 1ns/1ps
module step_seq_bench;
  localparam int NSTEP = 4, NCOND = 4, TW = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_reset = 1'b0, cmd_enable = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_kind = '0, cfg_step = '0, cfg_cond = '0;
  logic [31:0] cfg_data = '0;
  logic [3:0] cond_drv = '0, cond_in;
  logic scen = 1'b0;
  logic [1:0] step_o;
  logic running_o, timer_ge_o, done_o, trig_irq_o, trig_cti_o, trig_xunit_o;
  logic [TW-1:0] timer_o;
  logic [CW-1:0] count_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign cond_in = (scen && step_o == 2'd1) ? {3'b000, timer_ge_o} : cond_drv;

  step_seq #(.NSTEP(NSTEP), .NCOND(NCOND), .TW(TW), .CW(CW)) u_step_seq (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_enable(cmd_enable),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_step(cfg_step), .cfg_cond(cfg_cond),
    .cfg_data(cfg_data), .cond_hit(cond_in), .step_o(step_o), .running_o(running_o),
    .timer_o(timer_o), .timer_ge_o(timer_ge_o), .count_o(count_o), .done_o(done_o),
    .trig_irq_o(trig_irq_o), .trig_cti_o(trig_cti_o), .trig_xunit_o(trig_xunit_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int kind, input int st, input int cd, input logic [31:0] d);
    cfg_we = 1; cfg_kind = 2'(kind); cfg_step = 2'(st); cfg_cond = 2'(cd); cfg_data = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic do_reset_cmd();
    cmd_reset = 1; tick(); cmd_reset = 0;
  endtask

  task automatic do_enable();
    cmd_enable = 1; tick(); cmd_enable = 0;
  endtask

  function automatic int lowest(input int m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    // R1: reset state
    tick(); tick();
    chk(!running_o && step_o == 0 && timer_o == 0 && count_o == 0 && !done_o && !trig_irq_o,
        "R1 reset state", {running_o, step_o, done_o, trig_irq_o}, 0);
    rst_n = 1; tick();

    // R11: stopped unit ignores conditions; R13 writes
    wr(0, 0, 0, 32'h22209);
    cond_drv = 4'b0001;
    for (int k = 0; k < 5; k++) tick();
    chk(step_o == 0 && timer_o == 0 && count_o == 0 && !done_o && !trig_irq_o,
        "R11 idle hold", {step_o, count_o, done_o, trig_irq_o}, 0);
    cond_drv = 0;
    do_enable();
    chk(running_o && step_o == 0 && timer_o == 0 && count_o == 0, "R2 enable start",
        {running_o, step_o}, 4);
    cond_drv = 4'b0001; tick(); cond_drv = 0;
    chk(step_o == 1 && count_o == 1 && done_o && trig_irq_o && trig_cti_o && trig_xunit_o,
        "R13 R5 stored action applied", {step_o, count_o}, {2'd1, 3'd1});
    // R1: reset command wipes config
    do_reset_cmd();
    chk(!running_o && step_o == 0 && !done_o && count_o == 0, "R1 cmd reset", {running_o, done_o}, 0);
    do_enable();
    cond_drv = 4'b0001; tick(); cond_drv = 0;
    chk(step_o == 0 && count_o == 0 && !trig_irq_o && !done_o, "R1 config wiped",
        {step_o, count_o, trig_irq_o}, 0);

    // R3 R4 R5: priority sweep over all masks, defaults hold step
    do_reset_cmd();
    for (int i = 0; i < 4; i++) wr(0, 0, i, 32'(i) << 17);
    for (int s = 0; s < 4; s++) wr(1, s, 0, 32'h60000);
    for (int m = 0; m < 16; m++) begin
      do_enable();
      cond_drv = 4'(m); tick(); cond_drv = 0;
      if (m == 0) chk(step_o == 0, "R4 default holds step", step_o, 0);
      else chk(step_o == 2'(lowest(m)), "R3 lowest condition wins", step_o, lowest(m));
      tick();
      chk(step_o == 2'(lowest(m) < 0 ? 0 : lowest(m)), "R4 default next ignored", step_o,
          lowest(m) < 0 ? 0 : lowest(m));
    end

    // R6: trigger pulses
    do_reset_cmd();
    wr(0, 0, 0, 32'h2000);
    do_enable();
    cond_drv = 4'b0001; tick(); cond_drv = 0;
    chk(trig_irq_o && trig_cti_o && trig_xunit_o, "R6 trigger fan-out", trig_irq_o, 1);
    tick();
    chk(!trig_irq_o && !trig_cti_o && !trig_xunit_o, "R6 trigger one cycle", trig_irq_o, 0);
    cond_drv = 4'b0001;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(trig_irq_o, "R6 trigger each applied cycle", trig_irq_o, 1);
    end
    cond_drv = 0; tick();
    chk(!trig_irq_o, "R6 trigger drops", trig_irq_o, 0);

    // R7 R8: timer sweep against arithmetic model
    begin
      int t, run, act, mask;
      int tab[4] = '{32'h8, 32'h4, 32'hA, 32'h0};
      do_reset_cmd();
      for (int i = 0; i < 4; i++) wr(0, 0, i, 32'(tab[i]));
      wr(2, 0, 0, 32'd5);
      do_enable();
      t = 0; run = 0;
      for (int k = 0; k < 90; k++) begin
        mask = (k < 26) ? (k == 0 ? 1 : 0) : ((k * 11 + 3) % 16);
        if (k >= 26 && k % 7 == 0) mask = 0;
        act = (mask == 0) ? 0 : tab[lowest(mask)];
        cond_drv = 4'(mask); tick();
        if (act[1]) t = 0;
        else if (run != 0 && t != 15) t++;
        if (act[2]) run = 0; else if (act[3]) run = 1;
        chk(timer_o == 4'(t), "R7 timer model", timer_o, t);
        chk(timer_ge_o == (t >= 5), "R8 timer compare", timer_ge_o, t >= 5);
      end
      cond_drv = 0;
    end

    // R9: counter sweep against arithmetic model
    begin
      int c, act, mask;
      int tab[4] = '{32'h200, 32'h100, 32'h280, 32'h300};
      do_reset_cmd();
      for (int i = 0; i < 4; i++) wr(0, 0, i, 32'(tab[i]));
      do_enable();
      c = 0;
      for (int k = 0; k < 70; k++) begin
        mask = (k < 12) ? 1 : (k < 24) ? 2 : ((k * 5 + 1) % 16);
        act = (mask == 0) ? 0 : tab[lowest(mask)];
        cond_drv = 4'(mask); tick();
        if (act[7]) c = 0;
        else if (act[9] && !act[8] && c != 7) c++;
        else if (act[8] && !act[9] && c != 0) c--;
        chk(count_o == 3'(c), "R9 counter model", count_o, c);
      end
      cond_drv = 0;
    end

    // R10: sticky done
    do_reset_cmd();
    wr(0, 0, 0, 32'h1);
    do_enable();
    cond_drv = 4'b0001; tick(); cond_drv = 0;
    chk(done_o, "R10 done set", done_o, 1);
    tick(); tick();
    do_enable();
    chk(done_o, "R10 done survives enable", done_o, 1);
    do_reset_cmd();
    chk(!done_o, "R10 done cleared by reset command", done_o, 0);

    // R12: two-step timer scenario
    begin
      int trigs;
      wr(0, 0, 0, 32'h20008);
      wr(0, 0, 1, 32'h20008);
      wr(0, 1, 0, 32'h6);
      wr(1, 1, 0, 32'h2000);
      wr(2, 1, 0, 32'd3);
      scen = 1;
      do_enable();
      cond_drv = 4'b0010; tick(); cond_drv = 0;
      chk(step_o == 1 && timer_o == 0, "R12 enter step 1", step_o, 1);
      trigs = 0;
      for (int k = 0; k < 4; k++) begin
        tick();
        if (trig_irq_o) trigs++;
      end
      chk(step_o == 0 && timer_o == 0 && !trig_irq_o, "R12 return to step 0", step_o, 0);
      for (int k = 0; k < 3; k++) begin
        tick();
        if (trig_irq_o) trigs++;
      end
      chk(trigs == 3, "R12 trigger count", trigs, 3);
      chk(timer_o == 0 && step_o == 0, "R12 timer stopped", timer_o, 0);
      scen = 0;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule